// File: doc/BRIEF.md
# Undervoltage and Soft-Start Supervisor

This block decides when a switching converter may run. It watches a digitised reading of the supply rail and of an external lockout divider. Both readings are compared against turn-on and turn-off levels with hysteresis. Each comparison result is synchronised and has to stay stable before it is accepted. When both inputs are valid, the block enables the reference and the switching stage. It then raises a digital soft-start ramp, and the duty command passed on to the modulator can never exceed that ramp.

The same ramp also acts as an overload timer. On every ramp tick in which cycle-by-cycle current limiting is flagged, the ramp steps down by the same amount it would otherwise have climbed. If limiting lasts long enough to bring the ramp down to its low level, switching stops and a fault is raised. The ramp height reached before the overload, together with the step size, therefore sets how long an overload is tolerated. When the limit flag clears, a fresh ramp starts from zero. Any undervoltage on the rail or on the lockout input discharges the ramp at once and drops every enable.

Top module: `uvss_supervisor`

## Requirements
- R1: After reset, sw_en_o, ref_en_o, fault_o, ramp_o and duty_o are all zero.
- R2: The rail is taken as valid once rail_code_i >= START_LVL has been accepted. It stays valid until rail_code_i < STOP_LVL has been accepted. A reading between the two levels does not change the current decision.
- R3: When off, the lockout turns on once lock_code_i > lock_thr_i. While on, it stays on as long as lock_code_i + lock_hyst_i > lock_thr_i.
- R4: ref_en_o is high exactly when the rail and the lockout are both valid. sw_en_o is high only when ref_en_o is high and no fault is pending.
- R5: A change of any threshold comparison takes effect only after a two-flop synchroniser and STABLE_CYC consecutive cycles of the new value. A shorter excursion has no effect.
- R6: While running without current limit, ramp_o starts at 0 and increases by ramp_step_i once every RAMP_DIV cycles. It saturates at RAMP_MAX.
- R7: When an undervoltage is accepted on the rail or the lockout, ramp_o becomes 0 and sw_en_o and ref_en_o go low.
- R8: On a ramp tick while ilim_i is high, ramp_o decreases by ramp_step_i, down to no lower than 0.
- R9: If a decrease under ilim_i leaves the ramp at or below RAMP_LOW, then sw_en_o falls, fault_o rises and ramp_o becomes 0.
- R10: The fault holds while ilim_i stays high. Once ilim_i is low, fault_o clears, switching resumes and the ramp restarts from 0.
- R11: duty_o equals the smaller of err_cmd_i and ramp_o while sw_en_o is high, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rail_code_i | input | RDW | Digitised supply rail reading |
| lock_code_i | input | LDW | Digitised lockout divider reading |
| lock_thr_i | input | LDW | Lockout turn-on level |
| lock_hyst_i | input | LDW | Offset added to the lockout reading while on |
| ilim_i | input | 1 | Cycle-by-cycle current limit active |
| ramp_step_i | input | RW | Ramp increment and decrement per tick |
| err_cmd_i | input | RW | Duty command from the error loop |
| sw_en_o | output | 1 | Switching enable |
| ref_en_o | output | 1 | Reference enable |
| ramp_o | output | RW | Soft-start ramp value |
| duty_o | output | RW | Limited duty command |
| fault_o | output | 1 | Sustained overload fault |

## Verification
The bench builds the block with RAMP_DIV=4 and STABLE_CYC=8 in place of the slower defaults. With these values one ramp tick is exactly four clocks, so a single step of the charge or the overload pull-down can be measured between two samples. The clamp at RAMP_MAX and a complete overload countdown to fault both finish within a few hundred cycles. The short filter window also makes it possible to check both sides of R5 directly: a three-cycle glitch is rejected, and a twenty-cycle drop shuts the converter down.

// File: rtl/uvss_pkg.sv
// Shared types for the undervoltage and soft-start supervisor.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package uvss_pkg;
    // Sequencer states: dark, running with ramp, held off by overload fault.
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_FAULT = 2'd2
    } uvss_state_e;

    // Bit positions inside the comparison flag vector.
    localparam int FLG_START = 0;
    localparam int FLG_STOP  = 1;
    localparam int FLG_LOCK  = 2;
    localparam int NFLAG     = 3;
endpackage

// File: rtl/uvss_filter.sv
// Synchroniser plus stability filter for one comparison flag.
// Assumes: raw_i may be asynchronous; STABLE_CYC >= 1.
// The output follows the input only after STABLE_CYC cycles of agreement.
module uvss_filter #(
    parameter int STABLE_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic flag_o
);
    localparam int CW = $clog2(STABLE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(STABLE_CYC - 1);

    logic            s1_q, s2_q;
    logic [CW-1:0]   cnt_q;

    // Two-flop synchroniser.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else begin
            s1_q <= raw_i;
            s2_q <= s1_q;
        end
    end

    // Count consecutive disagreement; accept the new value when it lasts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            flag_o <= 1'b0;
        end else if (s2_q == flag_o) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q  <= '0;
            flag_o <= s2_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/uvss_levels.sv
// Threshold comparisons for the rail and the lockout input.
// Assumes: codes are unsigned. The lockout offset is applied only while
// the accepted lockout state is on, which gives the turn-off level.
module uvss_levels
    import uvss_pkg::*;
#(
    parameter int RDW       = 10,
    parameter int LDW       = 10,
    parameter int START_LVL = 850,
    parameter int STOP_LVL  = 774
) (
    input  logic [RDW-1:0]   rail_code_i,
    input  logic [LDW-1:0]   lock_code_i,
    input  logic [LDW-1:0]   lock_thr_i,
    input  logic [LDW-1:0]   lock_hyst_i,
    input  logic             lock_on_i,
    output logic [NFLAG-1:0] raw_o
);
    localparam logic [RDW-1:0] START_C = RDW'(START_LVL);
    localparam logic [RDW-1:0] STOP_C  = RDW'(STOP_LVL);

    logic [LDW:0] lock_sum;

    // Raw comparisons; the lockout level depends on the current state.
    always_comb begin
        lock_sum           = {1'b0, lock_code_i} + {1'b0, lock_hyst_i};
        raw_o[FLG_START]   = (rail_code_i >= START_C);
        raw_o[FLG_STOP]    = (rail_code_i >= STOP_C);
        raw_o[FLG_LOCK]    = lock_on_i ? (lock_sum > {1'b0, lock_thr_i})
                                       : (lock_code_i > lock_thr_i);
    end
endmodule

// File: rtl/uvss_seq.sv
// Start-up sequencer and soft-start ramp with overload countdown.
// Assumes: flags are already filtered; ilim_i is synchronous to clk.
// One ramp tick every RAMP_DIV cycles while running.
module uvss_seq
    import uvss_pkg::*;
#(
    parameter int RW       = 12,
    parameter int RAMP_MAX = 1000,
    parameter int RAMP_LOW = 20,
    parameter int RAMP_DIV = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] flag_i,
    input  logic             ilim_i,
    input  logic [RW-1:0]    ramp_step_i,
    output logic             sw_en_o,
    output logic             ref_en_o,
    output logic             fault_o,
    output logic [RW-1:0]    ramp_o
);
    localparam int DW = (RAMP_DIV > 1) ? $clog2(RAMP_DIV) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(RAMP_DIV - 1);
    localparam logic [RW:0]   MAX_W    = (RW+1)'(RAMP_MAX);
    localparam logic [RW-1:0] LOW_C    = RW'(RAMP_LOW);

    uvss_state_e    state_q;
    logic           rail_ok_q;
    logic [DW-1:0]  div_q;
    logic [RW-1:0]  ramp_q;
    logic [RW:0]    up_sum;
    logic [RW-1:0]  ramp_up, ramp_dn;
    logic           supply_good, tick;

    // Next ramp candidates and the tick strobe.
    always_comb begin
        up_sum      = {1'b0, ramp_q} + {1'b0, ramp_step_i};
        ramp_up     = (up_sum > MAX_W) ? MAX_W[RW-1:0] : up_sum[RW-1:0];
        ramp_dn     = (ramp_q > ramp_step_i) ? (ramp_q - ramp_step_i) : '0;
        tick        = (div_q == DIV_LAST);
        supply_good = rail_ok_q && flag_i[FLG_LOCK];
    end

    // Rail hysteresis: set on start level, clear below stop level.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rail_ok_q <= 1'b0;
        else if (!rail_ok_q && flag_i[FLG_START])
            rail_ok_q <= 1'b1;
        else if (rail_ok_q && !flag_i[FLG_STOP])
            rail_ok_q <= 1'b0;
    end

    // State, tick divider and ramp register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            div_q   <= '0;
            ramp_q  <= '0;
        end else begin
            case (state_q)
                ST_RUN: begin
                    if (!supply_good) begin
                        state_q <= ST_OFF;
                        div_q   <= '0;
                        ramp_q  <= '0;
                    end else if (tick) begin
                        div_q <= '0;
                        if (!ilim_i)
                            ramp_q <= ramp_up;
                        else if (ramp_dn <= LOW_C) begin
                            state_q <= ST_FAULT;
                            ramp_q  <= '0;
                        end else
                            ramp_q <= ramp_dn;
                    end else begin
                        div_q <= div_q + 1'b1;
                    end
                end
                ST_FAULT: begin
                    div_q  <= '0;
                    ramp_q <= '0;
                    if (!supply_good)
                        state_q <= ST_OFF;
                    else if (!ilim_i)
                        state_q <= ST_RUN;
                end
                default: begin
                    div_q  <= '0;
                    ramp_q <= '0;
                    if (supply_good)
                        state_q <= ST_RUN;
                end
            endcase
        end
    end

    // Decode outputs from the state register.
    always_comb begin
        sw_en_o  = (state_q == ST_RUN);
        ref_en_o = (state_q != ST_OFF);
        fault_o  = (state_q == ST_FAULT);
        ramp_o   = ramp_q;
    end
endmodule

// File: rtl/uvss_supervisor.sv
// Top: undervoltage and soft-start supervisor.
// Assumes: codes come from a sampled measurement path; outputs feed a PWM.
// Filters the three comparisons, sequences start-up and limits duty.
module uvss_supervisor
    import uvss_pkg::*;
#(
    parameter int RDW        = 10,
    parameter int LDW        = 10,
    parameter int RW         = 12,
    parameter int START_LVL  = 850,
    parameter int STOP_LVL   = 774,
    parameter int RAMP_MAX   = 1000,
    parameter int RAMP_LOW   = 20,
    parameter int RAMP_DIV   = 64,
    parameter int STABLE_CYC = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [RDW-1:0] rail_code_i,
    input  logic [LDW-1:0] lock_code_i,
    input  logic [LDW-1:0] lock_thr_i,
    input  logic [LDW-1:0] lock_hyst_i,
    input  logic           ilim_i,
    input  logic [RW-1:0]  ramp_step_i,
    input  logic [RW-1:0]  err_cmd_i,
    output logic           sw_en_o,
    output logic           ref_en_o,
    output logic [RW-1:0]  ramp_o,
    output logic [RW-1:0]  duty_o,
    output logic           fault_o
);
    logic [NFLAG-1:0] raw_flags;
    logic [NFLAG-1:0] filt_flags;

    uvss_levels #(
        .RDW(RDW), .LDW(LDW), .START_LVL(START_LVL), .STOP_LVL(STOP_LVL)
    ) levels_i (
        .rail_code_i (rail_code_i),
        .lock_code_i (lock_code_i),
        .lock_thr_i  (lock_thr_i),
        .lock_hyst_i (lock_hyst_i),
        .lock_on_i   (filt_flags[FLG_LOCK]),
        .raw_o       (raw_flags)
    );

    for (genvar g = 0; g < NFLAG; g++) begin : g_filt
        uvss_filter #(.STABLE_CYC(STABLE_CYC)) filt_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_flags[g]),
            .flag_o (filt_flags[g])
        );
    end

    uvss_seq #(
        .RW(RW), .RAMP_MAX(RAMP_MAX), .RAMP_LOW(RAMP_LOW), .RAMP_DIV(RAMP_DIV)
    ) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .flag_i      (filt_flags),
        .ilim_i      (ilim_i),
        .ramp_step_i (ramp_step_i),
        .sw_en_o     (sw_en_o),
        .ref_en_o    (ref_en_o),
        .fault_o     (fault_o),
        .ramp_o      (ramp_o)
    );

    // Duty limiter: smaller of loop command and ramp, zero when stopped.
    always_comb begin
        if (!sw_en_o)
            duty_o = '0;
        else if (err_cmd_i < ramp_o)
            duty_o = err_cmd_i;
        else
            duty_o = ramp_o;
    end
endmodule

// File: rtl/uvss_checker.sv
// Property checker for uvss_supervisor, attached by bind below.
// Assumes: observes top-level ports only.
module uvss_checker #(
    parameter int RW       = 12,
    parameter int RAMP_MAX = 1000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ilim_i,
    input logic [RW-1:0] ramp_step_i,
    input logic [RW-1:0] err_cmd_i,
    input logic          sw_en_o,
    input logic          ref_en_o,
    input logic [RW-1:0] ramp_o,
    input logic [RW-1:0] duty_o,
    input logic          fault_o
);
    p_en_needs_ref_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sw_en_o |-> (ref_en_o && !fault_o));

    p_ramp_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_o <= RW'(RAMP_MAX));

    p_rise_by_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_o > $past(ramp_o)) |-> ((ramp_o - $past(ramp_o)) <= $past(ramp_step_i)));

    p_off_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_en_o |-> (ramp_o == '0 && !sw_en_o && !fault_o));

    p_no_rise_in_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ilim_i) && $past(sw_en_o)) |-> (ramp_o <= $past(ramp_o)));

    p_fault_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (!sw_en_o && ramp_o == '0));

    p_duty_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_o <= ramp_o) && (duty_o <= err_cmd_i));
endmodule

bind uvss_supervisor uvss_checker #(.RW(RW), .RAMP_MAX(RAMP_MAX)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ilim_i      (ilim_i),
    .ramp_step_i (ramp_step_i),
    .err_cmd_i   (err_cmd_i),
    .sw_en_o     (sw_en_o),
    .ref_en_o    (ref_en_o),
    .ramp_o      (ramp_o),
    .duty_o      (duty_o),
    .fault_o     (fault_o)
);

// File: tb/uvss_supervisor_tb_top.sv
// Directed bench for uvss_supervisor: one task per scenario.
module uvss_supervisor_tb_top;
    localparam int RW   = 12;
    localparam int RMAX = 1000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [9:0]    rail_code = '0;
    logic [9:0]    lock_code = '0;
    logic [9:0]    lock_thr = 10'd500;
    logic [9:0]    lock_hyst = 10'd60;
    logic          ilim = 1'b0;
    logic [RW-1:0] step = '0;
    logic [RW-1:0] err_cmd = '0;
    logic          sw_en, ref_en, fault;
    logic [RW-1:0] ramp, duty;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    uvss_supervisor #(
        .RDW(10), .LDW(10), .RW(RW), .START_LVL(850), .STOP_LVL(774),
        .RAMP_MAX(RMAX), .RAMP_LOW(20), .RAMP_DIV(4), .STABLE_CYC(8)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .rail_code_i(rail_code), .lock_code_i(lock_code),
        .lock_thr_i(lock_thr), .lock_hyst_i(lock_hyst), .ilim_i(ilim),
        .ramp_step_i(step), .err_cmd_i(err_cmd), .sw_en_o(sw_en),
        .ref_en_o(ref_en), .ramp_o(ramp), .duty_o(duty), .fault_o(fault)
    );

    // Advance n rising edges, then settle mid-cycle.
    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic t_reset;
        cyc(3);
        chk(sw_en == 0 && ref_en == 0 && fault == 0, "R1 enables", {sw_en, ref_en, fault}, 0);
        chk(ramp == 0 && duty == 0, "R1 ramp/duty", int'(ramp) + int'(duty), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_rail_hyst;
        lock_code = 10'd600; step = 12'd5;
        rail_code = 10'd800; cyc(40);
        chk(ref_en == 0, "R2 between levels from off", ref_en, 0);
        rail_code = 10'd900; cyc(40);
        chk(ref_en == 1, "R2 above start", ref_en, 1);
        chk(sw_en == 1, "R4 both valid runs", sw_en, 1);
        rail_code = 10'd800; cyc(40);
        chk(ref_en == 1, "R2 between levels from on", ref_en, 1);
        rail_code = 10'd700; cyc(40);
        chk(ref_en == 0 && sw_en == 0, "R7 rail uv disables", {ref_en, sw_en}, 0);
        chk(ramp == 0 && duty == 0, "R7 ramp discharged", ramp, 0);
        rail_code = 10'd900; cyc(40);
    endtask

    task automatic t_lock_hyst;
        lock_code = 10'd430; cyc(40);
        chk(ref_en == 0, "R3 lock below threshold", ref_en, 0);
        lock_code = 10'd460; cyc(40);
        chk(ref_en == 0, "R3 off stays off inside band", ref_en, 0);
        lock_code = 10'd520; cyc(40);
        chk(ref_en == 1, "R3 lock above threshold", ref_en, 1);
        lock_code = 10'd460; cyc(40);
        chk(ref_en == 1, "R3 on stays on inside band", ref_en, 1);
        lock_code = 10'd430; cyc(40);
        chk(ref_en == 0 && ramp == 0, "R7 lock uv discharges", ramp, 0);
        lock_code = 10'd600; cyc(40);
        chk(ref_en == 1, "R4 lock restored", ref_en, 1);
    endtask

    task automatic t_filter;
        int r0;
        r0 = int'(ramp);
        rail_code = 10'd700; cyc(3);
        rail_code = 10'd900; cyc(30);
        chk(ref_en == 1 && int'(ramp) > r0, "R5 short glitch ignored", ramp, r0 + 1);
        rail_code = 10'd700; cyc(20);
        chk(ref_en == 0, "R5 lasting drop accepted", ref_en, 0);
        rail_code = 10'd900; cyc(40);
    endtask

    task automatic t_ramp;
        int r;
        for (int i = 0; i < 3; i++) begin
            r = int'(ramp);
            cyc(4);
            chk(int'(ramp) == r + 5, "R6 one step per tick", ramp, r + 5);
        end
        step = 12'd50; cyc(200);
        chk(int'(ramp) == RMAX, "R6 clamp at max", ramp, RMAX);
    endtask

    task automatic t_duty;
        err_cmd = 12'd300; #1;
        chk(int'(duty) == 300, "R11 loop command smaller", duty, 300);
        err_cmd = 12'd2000; #1;
        chk(int'(duty) == RMAX, "R11 ramp smaller", duty, RMAX);
    endtask

    task automatic t_overload;
        int r;
        ilim = 1'b1; cyc(2);
        r = int'(ramp);
        cyc(4);
        chk(int'(ramp) == r - 50, "R8 pull-down per tick", ramp, r - 50);
        cyc(54);
        chk(fault == 0 && sw_en == 1, "R9 no early fault", fault, 0);
        cyc(50);
        chk(fault == 1 && sw_en == 0 && ramp == 0, "R9 fault after countdown", fault, 1);
        chk(duty == 0, "R11 no duty in fault", duty, 0);
        cyc(20);
        chk(fault == 1, "R10 fault holds under limit", fault, 1);
        ilim = 1'b0; cyc(12);
        chk(fault == 0 && sw_en == 1, "R10 restart after limit clears", fault, 0);
        chk(int'(ramp) >= 50 && int'(ramp) <= 150, "R10 ramp restarted", ramp, 100);
        ilim = 1'b1; cyc(60);
        chk(fault == 1, "R9 fault from low ramp", fault, 1);
        rail_code = 10'd700; cyc(40);
        chk(fault == 0 && ref_en == 0, "R7 uv clears fault", {fault, ref_en}, 0);
        ilim = 1'b0;
    endtask

    initial begin
        t_reset();
        t_rail_hyst();
        t_lock_hyst();
        t_filter();
        t_ramp();
        t_duty();
        t_overload();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule